// File: doc/BRIEF.md
# Multi-Channel Thermal Auto-Monitor Controller

This block watches up to four temperature-sensor channels and needs no software once it is running. A free-running period counter starts a scan at each boundary. The scan visits every enabled channel in turn and uses a start/done handshake with an external converter to take one code per channel. Each returned code is stored per channel and is compared against two raw-code thresholds, one for alarm and one for shutdown. A consecutive-sample debounce counter qualifies each comparison before it raises an event.

Alarm events set pending bits that can raise an interrupt. Shutdown events set pending bits and also latch a shutdown state for that channel. The latched state can drive a reset-unit output, a pin output, or both, with a programmable polarity. When the latest sample of any enabled channel is over a threshold, the controller switches to a second, shorter scan period so that a hot part is watched more closely. Software sets up the controller through a simple register read/write port. All thresholds are programmed as raw converter codes.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset all registers read 0, `conv_start` and `irq` are 0, and both shutdown outputs are 1, because the polarity defaults to active-low and the outputs are inactive.
- R2: Registers are decoded at these byte addresses on `reg_addr`:
  - 0x00: scratch word.
  - 0x04: mode word. Bit 0 runs the scan, bit 1 selects code sense, bits 4+n enable channel n, bit 8 selects shutdown polarity.
  - 0x08: enable word. Bit n enables the alarm interrupt of channel n, bit 4+n routes shutdown n to the pin, bit 8+n routes it to the reset unit.
  - 0x0C: pending flags.
  - 0x20+4n: channel code, read-only. Writes are ignored.
  - 0x30+4n: alarm threshold.
  - 0x40+4n: shutdown threshold.
  - 0x60: alarm debounce count.
  - 0x64: shutdown debounce count.
  - 0x68: normal period.
  - 0x6C: hot period.

  Each writable register reads back the value written.
- R3: While running, successive scan start pulses are exactly the normal period (in clock cycles) apart. Once the latest sample of any enabled channel is at or over its alarm or shutdown threshold, the spacing becomes the hot period.
- R4: A scan issues one single-cycle `conv_start` per enabled channel, in ascending channel order, skipping disabled channels, and waits for `conv_done` before the next. With mode bit 0 clear, no start is issued.
- R5: The channel code register holds the code of that channel's latest sample.
- R6: With mode bit 1 set, a sample is over a threshold when code >= threshold. With it clear, a sample is over when code <= threshold.
- R7: An event fires on every sample whose run of consecutive over-threshold samples has reached the debounce count (a count of 0 acts as 1). A sample that is not over restarts the run.
- R8: Pending bits 3:0 are alarm events of channels 3:0 and bits 7:4 are shutdown events. Writing 1 to a bit clears it, writing 0 leaves it, and a same-cycle event wins over the clear.
- R9: `irq` is high when any pending alarm bit with its enable bit set is high, or when any pending shutdown bit is high.
- R10: A shutdown event latches the channel's shutdown state until mode bit 0 is cleared. A latched channel asserts the pin output if enable bit 4+n is set and the reset-unit output if enable bit 8+n is set.
- R11: With mode bit 8 set the shutdown outputs are active-high, otherwise active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 2 | Channel being converted |
| conv_done | input | 1 | Conversion complete, code valid |
| conv_code | input | 12 | Converted code |
| irq | output | 1 | Interrupt request |
| shut_rst | output | 1 | Shutdown output to the reset unit |
| shut_pin | output | 1 | Shutdown output to the pin |

## Verification
A sample takes effect at the clock edge that sees `conv_done`. Its code, comparator result, debounce count, pending flag and shutdown latch are therefore all readable at the next falling edge. The bench converter model counts completions per channel and samples one falling edge after the completion it waits for. Register writes, polarity changes and routing changes show on the outputs right after the write edge. Clearing run mode releases the shutdown latch one edge later, so the bench waits one more cycle for that check. Scan spacing is measured between start pulses and compared with the programmed period only after a few scans, once a period change has settled.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam logic [7:0] A_USER  = 8'h00;
    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_INTEN = 8'h08;
    localparam logic [7:0] A_PEND  = 8'h0C;
    localparam logic [7:0] A_DATA  = 8'h20;
    localparam logic [7:0] A_ATHR  = 8'h30;
    localparam logic [7:0] A_STHR  = 8'h40;
    localparam logic [7:0] A_DEBA  = 8'h60;
    localparam logic [7:0] A_DEBS  = 8'h64;
    localparam logic [7:0] A_PERN  = 8'h68;
    localparam logic [7:0] A_PERH  = 8'h6C;

    localparam int B_AUTO  = 0;
    localparam int B_SENSE = 1;
    localparam int B_CHEN  = 4;
    localparam int B_POL   = 8;
    localparam int E_PIN   = 4;
    localparam int E_RST   = 8;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_e;
endpackage

// File: rtl/tmon_regs.sv
module tmon_regs
    import tmon_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int DEB_W  = 8,
    parameter int PER_W  = 16,
    parameter int CH_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         smp_valid,
    input  logic [CH_W-1:0]              smp_ch,
    input  logic [CODE_W-1:0]            smp_code,
    input  logic [NCH-1:0]               alarm_evt,
    input  logic [NCH-1:0]               shut_evt,
    output logic                         auto_en,
    output logic                         sense_up,
    output logic                         pol_hi,
    output logic [NCH-1:0]               ch_en,
    output logic [NCH-1:0]               int_alarm_en,
    output logic [NCH-1:0]               route_pin,
    output logic [NCH-1:0]               route_rst,
    output logic [NCH-1:0][CODE_W-1:0]   athr,
    output logic [NCH-1:0][CODE_W-1:0]   sthr,
    output logic [DEB_W-1:0]             deba,
    output logic [DEB_W-1:0]             debs,
    output logic [PER_W-1:0]             pern,
    output logic [PER_W-1:0]             perh,
    output logic [NCH-1:0]               pend_alarm,
    output logic [NCH-1:0]               pend_shut
);
    typedef struct packed {
        logic [31:0]                user;
        logic [8:0]                 ctrl;
        logic [11:0]                inten;
        logic [NCH-1:0][CODE_W-1:0] data;
        logic [NCH-1:0][CODE_W-1:0] athr;
        logic [NCH-1:0][CODE_W-1:0] sthr;
        logic [DEB_W-1:0]           deba;
        logic [DEB_W-1:0]           debs;
        logic [PER_W-1:0]           pern;
        logic [PER_W-1:0]           perh;
        logic [NCH-1:0]             pa;
        logic [NCH-1:0]             ps;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            if (reg_addr == A_USER)  d.user  = reg_wdata;
            if (reg_addr == A_CTRL)  d.ctrl  = reg_wdata[8:0];
            if (reg_addr == A_INTEN) d.inten = reg_wdata[11:0];
            if (reg_addr == A_DEBA)  d.deba  = reg_wdata[DEB_W-1:0];
            if (reg_addr == A_DEBS)  d.debs  = reg_wdata[DEB_W-1:0];
            if (reg_addr == A_PERN)  d.pern  = reg_wdata[PER_W-1:0];
            if (reg_addr == A_PERH)  d.perh  = reg_wdata[PER_W-1:0];
            if (reg_addr == A_PEND) begin
                d.pa = q.pa & ~reg_wdata[NCH-1:0];
                d.ps = q.ps & ~reg_wdata[4 +: NCH];
            end
            for (int n = 0; n < NCH; n++) begin
                if (reg_addr == A_ATHR + 8'(4 * n)) d.athr[n] = reg_wdata[CODE_W-1:0];
                if (reg_addr == A_STHR + 8'(4 * n)) d.sthr[n] = reg_wdata[CODE_W-1:0];
            end
        end
        if (smp_valid) d.data[smp_ch] = smp_code;
        d.pa = d.pa | alarm_evt;
        d.ps = d.ps | shut_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_USER)  reg_rdata = q.user;
        if (reg_addr == A_CTRL)  reg_rdata = 32'(q.ctrl);
        if (reg_addr == A_INTEN) reg_rdata = 32'(q.inten);
        if (reg_addr == A_DEBA)  reg_rdata = 32'(q.deba);
        if (reg_addr == A_DEBS)  reg_rdata = 32'(q.debs);
        if (reg_addr == A_PERN)  reg_rdata = 32'(q.pern);
        if (reg_addr == A_PERH)  reg_rdata = 32'(q.perh);
        if (reg_addr == A_PEND) begin
            reg_rdata[NCH-1:0]  = q.pa;
            reg_rdata[4 +: NCH] = q.ps;
        end
        for (int n = 0; n < NCH; n++) begin
            if (reg_addr == A_DATA + 8'(4 * n)) reg_rdata = 32'(q.data[n]);
            if (reg_addr == A_ATHR + 8'(4 * n)) reg_rdata = 32'(q.athr[n]);
            if (reg_addr == A_STHR + 8'(4 * n)) reg_rdata = 32'(q.sthr[n]);
        end
    end

    assign auto_en      = q.ctrl[B_AUTO];
    assign sense_up     = q.ctrl[B_SENSE];
    assign pol_hi       = q.ctrl[B_POL];
    assign ch_en        = q.ctrl[B_CHEN +: NCH];
    assign int_alarm_en = q.inten[NCH-1:0];
    assign route_pin    = q.inten[E_PIN +: NCH];
    assign route_rst    = q.inten[E_RST +: NCH];
    assign athr         = q.athr;
    assign sthr         = q.sthr;
    assign deba         = q.deba;
    assign debs         = q.debs;
    assign pern         = q.pern;
    assign perh         = q.perh;
    assign pend_alarm   = q.pa;
    assign pend_shut    = q.ps;

    // R8
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_evt != '0) |=> ((q.pa & $past(alarm_evt)) == $past(alarm_evt)));

    // R5
    data_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (q.data[$past(smp_ch)] == $past(smp_code)));
endmodule

// File: rtl/tmon_seq.sv
module tmon_seq
    import tmon_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int PER_W  = 16,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_en,
    input  logic [NCH-1:0]    ch_en,
    input  logic              hot,
    input  logic [PER_W-1:0]  pern,
    input  logic [PER_W-1:0]  perh,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    output logic              smp_valid,
    output logic [CH_W-1:0]   smp_ch,
    output logic [CODE_W-1:0] smp_code
);
    typedef struct packed {
        sq_state_e        state;
        logic [CH_W-1:0]  cur;
        logic [PER_W-1:0] cnt;
    } seq_t;

    seq_t q, d;

    logic [PER_W-1:0] per_sel;
    logic [PER_W:0]   cnt_inc;
    logic             wrap;
    logic             first_ok, next_ok;
    logic [CH_W-1:0]  first_idx, next_idx;

    assign per_sel = hot ? perh : pern;
    assign cnt_inc = {1'b0, q.cnt} + 1'b1;
    assign wrap    = cnt_inc >= {1'b0, per_sel};

    always_comb begin
        first_ok  = 1'b0;
        first_idx = '0;
        next_ok   = 1'b0;
        next_idx  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_en[i]) begin
                first_ok  = 1'b1;
                first_idx = CH_W'(i);
            end
            if (ch_en[i] && (i > int'(q.cur))) begin
                next_ok  = 1'b1;
                next_idx = CH_W'(i);
            end
        end
    end

    always_comb begin
        d = q;
        if (!auto_en) begin
            d.state = SQ_IDLE;
            d.cnt   = '0;
        end else begin
            d.cnt = wrap ? '0 : cnt_inc[PER_W-1:0];
            case (q.state)
                SQ_IDLE: begin
                    if (wrap && first_ok) begin
                        d.state = SQ_ISSUE;
                        d.cur   = first_idx;
                    end
                end
                SQ_ISSUE: d.state = SQ_WAIT;
                SQ_WAIT: begin
                    if (conv_done) begin
                        if (next_ok) begin
                            d.state = SQ_ISSUE;
                            d.cur   = next_idx;
                        end else begin
                            d.state = SQ_IDLE;
                        end
                    end
                end
                default: d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: SQ_IDLE, cur: '0, cnt: '0};
        else        q <= d;
    end

    assign conv_start = (q.state == SQ_ISSUE);
    assign conv_chan  = q.cur;
    assign smp_valid  = (q.state == SQ_WAIT) && conv_done;
    assign smp_ch     = q.cur;
    assign smp_code   = conv_code;

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R4
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !conv_start);
endmodule

// File: rtl/tmon_eval.sv
module tmon_eval #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int DEB_W  = 8,
    parameter int CH_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       auto_en,
    input  logic                       sense_up,
    input  logic [NCH-1:0]             ch_en,
    input  logic                       smp_valid,
    input  logic [CH_W-1:0]            smp_ch,
    input  logic [CODE_W-1:0]          smp_code,
    input  logic [NCH-1:0][CODE_W-1:0] athr,
    input  logic [NCH-1:0][CODE_W-1:0] sthr,
    input  logic [DEB_W-1:0]           deba,
    input  logic [DEB_W-1:0]           debs,
    output logic [NCH-1:0]             alarm_evt,
    output logic [NCH-1:0]             shut_evt,
    output logic [NCH-1:0]             shut_act,
    output logic                       hot
);
    typedef struct packed {
        logic [DEB_W-1:0] ca;
        logic [DEB_W-1:0] cs;
        logic             over;
        logic             shut;
    } ch_t;

    function automatic logic over_fn(input logic [CODE_W-1:0] code,
                                     input logic [CODE_W-1:0] thr,
                                     input logic up);
        return up ? (code >= thr) : (code <= thr);
    endfunction

    logic [DEB_W-1:0] deba_eff, debs_eff;
    logic [NCH-1:0]   over_v;

    assign deba_eff = (deba == '0) ? DEB_W'(1) : deba;
    assign debs_eff = (debs == '0) ? DEB_W'(1) : debs;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ch_t  c_q, c_d;
        logic sel, oa, os, aev, sev;

        always_comb begin
            c_d = c_q;
            sel = smp_valid && (smp_ch == CH_W'(n));
            oa  = over_fn(smp_code, athr[n], sense_up);
            os  = over_fn(smp_code, sthr[n], sense_up);
            aev = 1'b0;
            sev = 1'b0;
            if (!auto_en) begin
                c_d = '0;
            end else if (sel) begin
                c_d.ca   = oa ? ((c_q.ca >= deba_eff) ? c_q.ca : c_q.ca + 1'b1) : '0;
                c_d.cs   = os ? ((c_q.cs >= debs_eff) ? c_q.cs : c_q.cs + 1'b1) : '0;
                aev      = oa && (c_d.ca >= deba_eff);
                sev      = os && (c_d.cs >= debs_eff);
                c_d.shut = c_q.shut | sev;
                c_d.over = oa | os;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign alarm_evt[n] = aev;
        assign shut_evt[n]  = sev;
        assign shut_act[n]  = c_q.shut;
        assign over_v[n]    = c_q.over;

        // R10
        shut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (auto_en && c_q.shut) |=> c_q.shut);
    end

    assign hot = |(over_v & ch_en);
endmodule

// File: rtl/thermal_scan_ctrl.sv
module thermal_scan_ctrl #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int DEB_W  = 8,
    parameter int PER_W  = 16,
    parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] conv_code,
    output logic              irq,
    output logic              shut_rst,
    output logic              shut_pin
);
    logic                       auto_en, sense_up, pol_hi, hot;
    logic [NCH-1:0]             ch_en, int_alarm_en, route_pin, route_rst;
    logic [NCH-1:0][CODE_W-1:0] athr, sthr;
    logic [DEB_W-1:0]           deba, debs;
    logic [PER_W-1:0]           pern, perh;
    logic [NCH-1:0]             pend_alarm, pend_shut;
    logic [NCH-1:0]             alarm_evt, shut_evt, shut_act;
    logic                       smp_valid;
    logic [CH_W-1:0]            smp_ch;
    logic [CODE_W-1:0]          smp_code;
    logic                       pin_act, rst_act;

    tmon_regs #(.NCH(NCH), .CODE_W(CODE_W), .DEB_W(DEB_W), .PER_W(PER_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_code(smp_code),
        .alarm_evt(alarm_evt), .shut_evt(shut_evt),
        .auto_en(auto_en), .sense_up(sense_up), .pol_hi(pol_hi), .ch_en(ch_en),
        .int_alarm_en(int_alarm_en), .route_pin(route_pin), .route_rst(route_rst),
        .athr(athr), .sthr(sthr), .deba(deba), .debs(debs), .pern(pern), .perh(perh),
        .pend_alarm(pend_alarm), .pend_shut(pend_shut)
    );

    tmon_seq #(.NCH(NCH), .CODE_W(CODE_W), .PER_W(PER_W), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .ch_en(ch_en), .hot(hot),
        .pern(pern), .perh(perh), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_code(conv_code),
        .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_code(smp_code)
    );

    tmon_eval #(.NCH(NCH), .CODE_W(CODE_W), .DEB_W(DEB_W), .CH_W(CH_W)) u_eval (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .sense_up(sense_up), .ch_en(ch_en),
        .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_code(smp_code),
        .athr(athr), .sthr(sthr), .deba(deba), .debs(debs),
        .alarm_evt(alarm_evt), .shut_evt(shut_evt), .shut_act(shut_act), .hot(hot)
    );

    assign irq      = (|(pend_alarm & int_alarm_en)) | (|pend_shut);
    assign pin_act  = |(shut_act & route_pin);
    assign rst_act  = |(shut_act & route_rst);
    assign shut_pin = pol_hi ? pin_act : ~pin_act;
    assign shut_rst = pol_hi ? rst_act : ~rst_act;
endmodule

// File: tb/thermal_scan_ctrl_test.sv
`timescale 1ns/1ps
module thermal_scan_ctrl_test;
    localparam logic [7:0] CTRL = 8'h04, INTEN = 8'h08, PEND = 8'h0C, DATA = 8'h20,
                           ATHR = 8'h30, STHR = 8'h40, DEBA = 8'h60, DEBS = 8'h64,
                           PERN = 8'h68, PERH = 8'h6C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_start;
    logic [1:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;
    logic        irq, shut_rst, shut_pin;

    always #4 clk = ~clk;

    thermal_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_code(conv_code),
        .irq(irq), .shut_rst(shut_rst), .shut_pin(shut_pin)
    );

    int checks = 0, fails = 0;
    int model_code[4];
    int done_cnt[4];
    int log_ch[64];
    int log_n = 0;
    int cyc = 0, last_start = 0, prev_start = 0;
    int lat_left = 0, lat_ch = 0;

    // converter model: done with the code three falling edges after a start
    initial begin
        for (int i = 0; i < 4; i++) begin
            model_code[i] = 0;
            done_cnt[i] = 0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            conv_done = 1'b0;
            if (lat_left > 0) begin
                lat_left--;
                if (lat_left == 0) begin
                    conv_done = 1'b1;
                    conv_code = 12'(model_code[lat_ch]);
                    done_cnt[lat_ch]++;
                end
            end else if (conv_start) begin
                lat_ch = int'(conv_chan);
                lat_left = 3;
                prev_start = last_start;
                last_start = cyc;
                if (log_n < 64) begin
                    log_ch[log_n] = lat_ch;
                    log_n++;
                end
            end
        end
    end

    function automatic bit over_exp(int code, int thr, bit up);
        return up ? (code >= thr) : (code <= thr);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_samples(input int ch, input int k);
        int base;
        base = done_cnt[ch];
        while (done_cnt[ch] < base + k) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int codes[4], thr[4];
        bit up;
        int n0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, v);  chk("R1 ctrl", v, 0);
        rd(PEND, v);  chk("R1 pend", v, 0);
        rd(DATA, v);  chk("R1 data0", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 start", conv_start, 0);
        chk("R1 shut_pin", shut_pin, 1);
        chk("R1 shut_rst", shut_rst, 1);

        // R2 register map readback
        wr(8'h00, 32'hA5A51234); rd(8'h00, v); chk("R2 scratch", v, 32'hA5A51234);
        wr(ATHR + 8'd8, 32'h123); rd(ATHR + 8'd8, v); chk("R2 athr2", v, 32'h123);
        wr(PERH, 32'h77); rd(PERH, v); chk("R2 perh", v, 32'h77);
        wr(DATA + 8'd4, 32'h55); rd(DATA + 8'd4, v); chk("R2 data ro", v, 0);

        // R5/R6 constrained random comparisons, debounce 1
        void'($urandom(32'd1234));
        for (int it = 0; it < 12; it++) begin
            up = 1'($urandom % 2);
            wr(CTRL, 0); wr(DEBA, 1); wr(DEBS, 1); wr(PERN, 40); wr(PERH, 40); wr(INTEN, 0);
            for (int c = 0; c < 4; c++) begin
                codes[c] = 1 + int'($urandom % 4094);
                thr[c] = int'($urandom % 4096);
                if (it < 2 && c == 0) thr[c] = codes[c];
                model_code[c] = codes[c];
                wr(ATHR + 8'(4 * c), 32'(thr[c]));
                wr(STHR + 8'(4 * c), up ? 32'd4095 : 32'd0);
            end
            wr(PEND, 32'hFF);
            wr(CTRL, 32'h1 | (32'(up) << 1) | 32'hF0);
            wait_samples(3, 2);
            rd(PEND, v);
            for (int c = 0; c < 4; c++) begin
                logic [31:0] dv;
                rd(DATA + 8'(4 * c), dv);
                chk("R5 data", dv, 32'(codes[c]));
                chk("R6 compare", v[c], over_exp(codes[c], thr[c], up));
            end
        end

        // R4 scan order with channel 1 disabled
        wr(CTRL, 0);
        for (int c = 0; c < 4; c++) begin
            model_code[c] = 100;
            wr(ATHR + 8'(4 * c), 4000);
            wr(STHR + 8'(4 * c), 4095);
        end
        log_n = 0;
        wr(CTRL, 32'h1 | 32'h2 | 32'hD0);
        wait_samples(3, 1);
        chk("R4 count", log_n, 3);
        chk("R4 first", log_ch[0], 0);
        chk("R4 second", log_ch[1], 2);
        chk("R4 third", log_ch[2], 3);
        wr(CTRL, 32'hD0);
        repeat (10) @(negedge clk);
        n0 = log_n;
        repeat (120) @(negedge clk);
        chk("R4 no scan when off", log_n, n0);

        // R3 normal and hot periods, channel 0 only
        wr(PERN, 40); wr(PERH, 20); wr(ATHR, 2000);
        wr(CTRL, 32'h1 | 32'h2 | 32'h10);
        wait_samples(0, 3);
        chk("R3 normal gap", last_start - prev_start, 40);
        model_code[0] = 3000;
        wait_samples(0, 4);
        chk("R3 hot gap", last_start - prev_start, 20);
        model_code[0] = 100;
        wait_samples(0, 3);
        chk("R3 back to normal", last_start - prev_start, 40);

        // R7 debounce of 3 consecutive samples
        wr(DEBA, 3);
        wr(PEND, 32'hFF);
        model_code[0] = 3000;
        wait_samples(0, 1); rd(PEND, v); chk("R7 after 1", v[0], 0);
        wait_samples(0, 1); rd(PEND, v); chk("R7 after 2", v[0], 0);
        wait_samples(0, 1); rd(PEND, v); chk("R7 after 3", v[0], 1);
        model_code[0] = 100;
        wait_samples(0, 1);
        wr(PEND, 32'hFF);
        model_code[0] = 3000;
        wait_samples(0, 2); rd(PEND, v); chk("R7 run restarted", v[0], 0);
        wait_samples(0, 1); rd(PEND, v); chk("R7 run complete", v[0], 1);

        // R8 write-one-to-clear
        model_code[0] = 100;
        wait_samples(0, 1);
        rd(PEND, v); chk("R8 sticky", v[0], 1);
        wr(PEND, 0); rd(PEND, v); chk("R8 write 0", v[0], 1);
        wr(PEND, 1); rd(PEND, v); chk("R8 write 1", v[0], 0);

        // R9 interrupt gating
        wr(DEBA, 1);
        wr(INTEN, 0);
        model_code[0] = 3000;
        wait_samples(0, 1);
        chk("R9 irq masked", irq, 0);
        wr(INTEN, 1);
        chk("R9 irq enabled", irq, 1);
        model_code[0] = 100;
        wait_samples(0, 1);
        wr(PEND, 32'hFF);
        chk("R9 irq cleared", irq, 0);

        // R10/R11 shutdown latch, routing and polarity, channel 1
        wr(CTRL, 0);
        wr(ATHR + 8'd4, 4000); wr(STHR + 8'd4, 2500); wr(DEBS, 2);
        wr(INTEN, 32'h20);
        model_code[1] = 3000;
        wr(CTRL, 32'h1 | 32'h2 | 32'h30);
        wait_samples(1, 1);
        chk("R10 debounce pin idle", shut_pin, 1);
        wait_samples(1, 1);
        chk("R10 pin active low", shut_pin, 0);
        chk("R10 reset unit idle", shut_rst, 1);
        rd(PEND, v); chk("R8 shutdown pending", v[5], 1);
        chk("R9 irq from shutdown", irq, 1);
        model_code[1] = 100;
        wait_samples(1, 1);
        chk("R10 latched", shut_pin, 0);
        wr(CTRL, 32'h1 | 32'h2 | 32'h30 | 32'h100);
        chk("R11 pin active high", shut_pin, 1);
        chk("R11 reset unit idle low", shut_rst, 0);
        wr(INTEN, 32'h200);
        chk("R10 routed to reset unit", shut_rst, 1);
        chk("R10 pin unrouted", shut_pin, 0);
        wr(CTRL, 32'h2 | 32'h30 | 32'h100);
        @(negedge clk);
        chk("R10 released by mode off", shut_rst, 0);

        finish_run();
    end
endmodule